// File: doc/BRIEF.md
# Frame and Multiframe Sync Pulse Generator

This block counts cycles of a fast system clock to produce two aligned timing signals: a frame sync and a multiframe sync. With the default parameters and a 204.8 MHz system clock, one frame is 25600 clocks, so the frame sync runs at 8 kHz. The multiframe is four frames long, so the multiframe sync runs at 2 kHz. Outputs move in steps of one system clock, about 4.9 ns.

Two reference tick inputs come from the surrounding clock loop, and a configuration bit picks the one that is used. A small alignment state machine has two states. In `IDLE`, which is entered on reset, both outputs sit at their inactive level. In `RUN`, the counters are free-running. The first selected tick causes the *start* transition from `IDLE` to `RUN`. While in `RUN`, a selected tick that arrives anywhere other than the last clock of a frame causes the *realign* transition from `RUN` to `RUN`, which restarts the frame and multiframe counts at zero. A tick that arrives on the last clock of a frame agrees with the count and changes nothing.

Each output has two settings of its own:
- a pulse-mode bit, which chooses a one-clock pulse or a 50% duty square wave;
- an invert bit, which flips the output polarity.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset, and until the first selected tick, the state is `IDLE`. In `IDLE`, `fr_sync_o` equals cfg bit 3 and `mf_sync_o` equals cfg bit 1, which is the inactive level of each output.
- R2: A selected tick sampled at a clock edge while in `IDLE` moves the block to `RUN`. Starting in the cycle after that edge, frame count 0 and multiframe frame index 0 are presented.
- R3: In `RUN`, the frame count goes from 0 to FRAME_LEN-1 and then wraps. When cfg bit 2 is 1 (frame pulse mode), the frame sync is active for exactly the one clock at count 0.
- R4: The multiframe lasts FRAMES_PER_MF frames. When cfg bit 0 is 1 (multiframe pulse mode), the multiframe sync is active for one clock at count 0 of frame index 0, so it coincides with every FRAMES_PER_MF-th frame pulse, starting with the aligning one.
- R5: When cfg bit 2 is 0, the frame sync is active while the frame count is below FRAME_LEN/2.
- R6: When cfg bit 0 is 0, the multiframe sync is active while the frame index is below FRAMES_PER_MF/2.
- R7: An output level is the active flag XOR its invert bit. Cfg bit 3 inverts the frame sync and cfg bit 1 inverts the multiframe sync. Active is 1 when the invert bit is 0.
- R8: Cfg bit 4 selects the reference tick: 0 selects `tick_a_i` and 1 selects `tick_b_i`. A tick on the other input has no effect.
- R9: In `RUN`, a selected tick on any count other than FRAME_LEN-1 restarts both the frame count and the frame index at 0 in the next cycle. A selected tick at count FRAME_LEN-1 leaves the sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_a_i | input | 1 | Reference tick, source A |
| tick_b_i | input | 1 | Reference tick, source B |
| cfg_i | input | 5 | Bit 0 multiframe pulse mode; bit 1 multiframe invert; bit 2 frame pulse mode; bit 3 frame invert; bit 4 reference select |
| fr_sync_o | output | 1 | Frame sync |
| mf_sync_o | output | 1 | Multiframe sync |

## Verification
The bench runs every combination of pulse mode, square mode, polarity and reference source across complete multiframes. It compares each cycle against a cycle-count model.

It injects a tick on the unselected input, both while idle and in mid-frame. A design that muxes the wrong source would start early or realign, and the output would shift in time.

It sends a disagreeing tick in mid-frame and an agreeing tick on the last clock of a frame. A design that fails to clear the frame index on realign would put the multiframe pulse on the wrong frame. A design that treats an agreeing tick as a restart would reset the multiframe phase.

A reset in mid-run must bring both outputs straight back to their inactive levels.

// File: rtl/sync_pkg.sv
package sync_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } align_state_t;

    localparam int CFG_W        = 5;
    localparam int CFG_MF_PULSE = 0;
    localparam int CFG_MF_INV   = 1;
    localparam int CFG_FR_PULSE = 2;
    localparam int CFG_FR_INV   = 3;
    localparam int CFG_REF_SEL  = 4;

    localparam int NUM_SYNC = 2;
    localparam int IDX_FR   = 0;
    localparam int IDX_MF   = 1;

endpackage

// File: rtl/sync_align_fsm.sv
module sync_align_fsm
    import sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic at_last,
    output logic run,
    output logic restart
);

    align_state_t state_q;
    align_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: start (IDLE->RUN), realign (RUN->RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run     = 1'b0;
                restart = tick;
            end
            ST_RUN: begin
                run     = 1'b1;
                restart = tick && !at_last;
            end
            default: begin
                run     = 1'b0;
                restart = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sync_frame_ctr.sv
module sync_frame_ctr #(
    parameter int FRAME_LEN = 25600
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic                         restart,
    output logic [$clog2(FRAME_LEN)-1:0] count,
    output logic                         at_last,
    output logic                         at_start,
    output logic                         first_half
);

    localparam int FC_W = $clog2(FRAME_LEN);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_LEN - 1);
    localparam logic [FC_W-1:0] FC_HALF = FC_W'(FRAME_LEN / 2);

    logic [FC_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == FC_LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        count      = cnt_q;
        at_last    = (cnt_q == FC_LAST);
        at_start   = (cnt_q == '0);
        first_half = (cnt_q < FC_HALF);
    end

endmodule

// File: rtl/sync_mf_ctr.sv
module sync_mf_ctr #(
    parameter int FRAMES_PER_MF = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run,
    input  logic                             restart,
    input  logic                             frame_last,
    output logic [$clog2(FRAMES_PER_MF)-1:0] index,
    output logic                             at_start,
    output logic                             first_half
);

    localparam int FI_W = $clog2(FRAMES_PER_MF);
    localparam logic [FI_W-1:0] FI_LAST = FI_W'(FRAMES_PER_MF - 1);
    localparam logic [FI_W-1:0] FI_HALF = FI_W'(FRAMES_PER_MF / 2);

    logic [FI_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (restart) begin
            idx_q <= '0;
        end else if (run && frame_last) begin
            if (idx_q == FI_LAST) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        index      = idx_q;
        at_start   = (idx_q == '0);
        first_half = (idx_q < FI_HALF);
    end

endmodule

// File: rtl/sync_shaper.sv
module sync_shaper (
    input  logic run,
    input  logic pulse_mode,
    input  logic invert,
    input  logic pulse_hit,
    input  logic square_hit,
    output logic sync_o
);

    logic active;

    always_comb begin
        if (!run) begin
            active = 1'b0;
        end else if (pulse_mode) begin
            active = pulse_hit;
        end else begin
            active = square_hit;
        end
        sync_o = active ^ invert;
    end

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_pkg::*;
#(
    parameter int FRAME_LEN     = 25600,
    parameter int FRAMES_PER_MF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a_i,
    input  logic             tick_b_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             fr_sync_o,
    output logic             mf_sync_o
);

    localparam int FC_W = $clog2(FRAME_LEN);
    localparam int FI_W = $clog2(FRAMES_PER_MF);

    logic            tick_sel;
    logic            run;
    logic            restart;
    logic [FC_W-1:0] fc;
    logic            fc_last;
    logic            fc_start;
    logic            fc_half;
    logic [FI_W-1:0] fidx;
    logic            fi_start;
    logic            fi_half;

    logic [NUM_SYNC-1:0] sh_mode;
    logic [NUM_SYNC-1:0] sh_inv;
    logic [NUM_SYNC-1:0] sh_pulse;
    logic [NUM_SYNC-1:0] sh_square;
    logic [NUM_SYNC-1:0] sh_out;

    assign tick_sel = cfg_i[CFG_REF_SEL] ? tick_b_i : tick_a_i;

    sync_align_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_sel),
        .at_last (fc_last),
        .run     (run),
        .restart (restart)
    );

    sync_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (restart),
        .count      (fc),
        .at_last    (fc_last),
        .at_start   (fc_start),
        .first_half (fc_half)
    );

    sync_mf_ctr #(.FRAMES_PER_MF(FRAMES_PER_MF)) u_mf (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .restart    (restart),
        .frame_last (fc_last),
        .index      (fidx),
        .at_start   (fi_start),
        .first_half (fi_half)
    );

    always_comb begin
        sh_mode[IDX_FR]   = cfg_i[CFG_FR_PULSE];
        sh_inv[IDX_FR]    = cfg_i[CFG_FR_INV];
        sh_pulse[IDX_FR]  = fc_start;
        sh_square[IDX_FR] = fc_half;
        sh_mode[IDX_MF]   = cfg_i[CFG_MF_PULSE];
        sh_inv[IDX_MF]    = cfg_i[CFG_MF_INV];
        sh_pulse[IDX_MF]  = fc_start && fi_start;
        sh_square[IDX_MF] = fi_half;
    end

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_shaper
        sync_shaper u_sh (
            .run        (run),
            .pulse_mode (sh_mode[g]),
            .invert     (sh_inv[g]),
            .pulse_hit  (sh_pulse[g]),
            .square_hit (sh_square[g]),
            .sync_o     (sh_out[g])
        );
    end

    assign fr_sync_o = sh_out[IDX_FR];
    assign mf_sync_o = sh_out[IDX_MF];

endmodule

// File: rtl/sync_gen_chk.sv
module sync_gen_chk #(
    parameter int FRAME_LEN     = 25600,
    parameter int FRAMES_PER_MF = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             tick_sel,
    input logic                             run,
    input logic [$clog2(FRAME_LEN)-1:0]     fc,
    input logic [$clog2(FRAMES_PER_MF)-1:0] fidx,
    input logic [4:0]                       cfg_i,
    input logic                             fr_sync_o,
    input logic                             mf_sync_o
);

    localparam int FC_W = $clog2(FRAME_LEN);
    localparam int FI_W = $clog2(FRAMES_PER_MF);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_LEN - 1);
    localparam logic [FI_W-1:0] FI_LAST = FI_W'(FRAMES_PER_MF - 1);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fc <= FC_LAST) && (fidx <= FI_LAST)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (fr_sync_o == cfg_i[3]) && (mf_sync_o == cfg_i[1])); // R1

    AST_START_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && tick_sel) |=> (run && (fc == '0) && (fidx == '0))); // R2

    AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_sel && (fc != FC_LAST)) |=> ((fc == '0) && (fidx == '0))); // R9

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_sel && (fc != FC_LAST)) |=> (fc == $past(fc) + 1'b1)); // R3

    AST_MF_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[0] && cfg_i[2] && (mf_sync_o != cfg_i[1])) |-> (fr_sync_o != cfg_i[3])); // R4

    AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg_i[2] && !tick_sel && (fr_sync_o != cfg_i[3]))
        |=> (!$stable(cfg_i) || (fr_sync_o == cfg_i[3]))); // R3

endmodule

bind sync_pulse_gen sync_gen_chk #(
    .FRAME_LEN     (FRAME_LEN),
    .FRAMES_PER_MF (FRAMES_PER_MF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_sel  (tick_sel),
    .run       (run),
    .fc        (fc),
    .fidx      (fidx),
    .cfg_i     (cfg_i),
    .fr_sync_o (fr_sync_o),
    .mf_sync_o (mf_sync_o)
);

// File: tb/tb_sync_pulse_gen.sv
module tb_sync_pulse_gen;

    localparam int F = 8;
    localparam int M = 4;
    localparam int NVEC = 8;
    localparam logic [4:0] CFG_TAB [NVEC] = '{
        5'b00101, 5'b00000, 5'b01111, 5'b01010,
        5'b10101, 5'b11011, 5'b10100, 5'b00001
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_a_i = 1'b0;
    logic       tick_b_i = 1'b0;
    logic [4:0] cfg_i = 5'b0;
    logic       fr_sync_o;
    logic       mf_sync_o;

    int n_checks = 0;
    int n_fail = 0;
    int n = -1;
    string phase_tag = "R1";

    always #5 clk = ~clk;

    sync_pulse_gen #(.FRAME_LEN(F), .FRAMES_PER_MF(M)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_a_i  (tick_a_i),
        .tick_b_i  (tick_b_i),
        .cfg_i     (cfg_i),
        .fr_sync_o (fr_sync_o),
        .mf_sync_o (mf_sync_o)
    );

    function automatic logic exp_fr(input int cnt, input logic [4:0] c);
        logic act;
        if (cnt < 0) act = 1'b0;
        else if (c[2]) act = ((cnt % F) == 0);
        else act = ((cnt % F) < F / 2);
        return act ^ c[3];
    endfunction

    function automatic logic exp_mf(input int cnt, input logic [4:0] c);
        logic act;
        int fi;
        fi = (cnt / F) % M;
        if (cnt < 0) act = 1'b0;
        else if (c[0]) act = ((cnt % F) == 0) && (fi == 0);
        else act = (fi < M / 2);
        return act ^ c[1];
    endfunction

    task automatic compare_outputs();
        logic ef, em;
        string tf, tm;
        ef = exp_fr(n, cfg_i);
        em = exp_mf(n, cfg_i);
        tf = cfg_i[2] ? "R3" : "R5";
        tm = cfg_i[0] ? "R4" : "R6";
        if (cfg_i[3]) tf = {tf, " R7"};
        if (cfg_i[1]) tm = {tm, " R7"};
        n_checks++;
        if (fr_sync_o !== ef) begin
            n_fail++;
            $display("FAIL %s %s frame cfg=%b n=%0d actual=%b expected=%b",
                     phase_tag, tf, cfg_i, n, fr_sync_o, ef);
        end
        n_checks++;
        if (mf_sync_o !== em) begin
            n_fail++;
            $display("FAIL %s %s multiframe cfg=%b n=%0d actual=%b expected=%b",
                     phase_tag, tm, cfg_i, n, mf_sync_o, em);
        end
    endtask

    task automatic step(input logic ta, input logic tb);
        logic sel_t;
        tick_a_i = ta;
        tick_b_i = tb;
        sel_t = cfg_i[4] ? tb : ta;
        @(negedge clk);
        tick_a_i = 1'b0;
        tick_b_i = 1'b0;
        if (n < 0) begin
            if (sel_t) n = 0;
        end else if (sel_t && ((n % F) != F - 1)) begin
            n = 0;
        end else begin
            n = n + 1;
        end
    endtask

    task automatic sel_tick(output logic ta, output logic tb, input logic own);
        ta = cfg_i[4] ? !own : own;
        tb = cfg_i[4] ? own : !own;
    endtask

    task automatic do_reset(input logic [4:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_i = c;
        n = -1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic ta, tb;
        for (int v = 0; v < NVEC; v++) begin
            do_reset(CFG_TAB[v]);
            phase_tag = "R1";
            compare_outputs();
            step(1'b0, 1'b0);
            compare_outputs();
            // R8: unselected tick while idle must not start the block
            phase_tag = "R8";
            sel_tick(ta, tb, 1'b0);
            step(ta, tb);
            compare_outputs();
            step(1'b0, 1'b0);
            compare_outputs();
            // R2: start on the selected tick
            phase_tag = "R2";
            sel_tick(ta, tb, 1'b1);
            step(ta, tb);
            compare_outputs();
            phase_tag = "R3";
            for (int k = 0; k < F * M + 3; k++) begin
                if (k == 5) begin
                    // R8: unselected tick in mid-frame is ignored
                    phase_tag = "R8";
                    sel_tick(ta, tb, 1'b0);
                    step(ta, tb);
                end else begin
                    step(1'b0, 1'b0);
                end
                compare_outputs();
            end
            // R9: disagreeing tick restarts frame and multiframe
            phase_tag = "R9";
            sel_tick(ta, tb, 1'b1);
            step(ta, tb);
            compare_outputs();
            for (int k = 0; k < 2 * F * M; k++) begin
                // R9: agreeing tick on last count of frame 1
                if (n == 2 * F - 1) begin
                    sel_tick(ta, tb, 1'b1);
                    step(ta, tb);
                end else begin
                    step(1'b0, 1'b0);
                end
                compare_outputs();
            end
        end

        // R1: reset in mid-run returns outputs to inactive level
        phase_tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        cfg_i = 5'b00101;
        n = -1;
        @(negedge clk);
        compare_outputs();
        rst_n = 1'b1;
        repeat (3) begin
            step(1'b0, 1'b0);
            compare_outputs();
        end

        // R8: switching the source bit changes which input aligns
        phase_tag = "R8";
        cfg_i = 5'b10101;
        step(1'b1, 1'b0);
        compare_outputs();
        step(1'b0, 1'b1);
        compare_outputs();
        for (int k = 0; k < F + 2; k++) begin
            step(1'b0, 1'b0);
            compare_outputs();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule